// File: doc/BRIEF.md
# Buffered Compare/Capture Register Bank

This block keeps a pending (buffer) value and an active value for each of six timer channels, plus one pending/active pair for the timer period and one for the output pattern. Each channel is set to compare or capture behaviour by its own mode input. In compare behaviour, software loads the buffer. An update strobe moves every pending buffer into its active register at once, unless the lock-update control holds the transfer back. In capture behaviour, a capture strobe stores the counter value into the buffer. A read strobe on the channel register consumes the pending value by moving it into the active register.

Every buffer has a valid flag, and the flags are shown in a 32-bit status word. The status word also carries the six compare-output levels, which come from the waveform logic outside this block. Software clears flags through a write-one-to-clear strobe with a 32-bit mask that uses the same bit positions as the status word. The counter, the waveform generator and the bus are outside the block; they appear here only as ports and single-cycle strobes.

Top module: `ccbuf_bank`

## Requirements
- R1: While reset is high, and after it, every valid flag, buffer and active value is zero. Status bits 5, 7 and 16 to 21 read 0.
- R2: A write strobe on a compare-mode channel (mode bit 0) loads the shared write data into its buffer. The channel's valid flag, at status bit 16+i, reads 1 from the next cycle.
- R3: An update strobe with lock-update low copies each valid compare buffer into its active register and clears its flag. A channel whose flag is clear keeps its active value. An active value changes only on an update strobe or a read strobe.
- R4: An update strobe with lock-update high copies no buffer and leaves the compare flags set.
- R5: Write-one-to-clear of a compare flag takes effect only while lock-update is high. With lock-update low, it is ignored.
- R6: If a compare buffer write and an update (lock low) fall in the same cycle, the previously pending value goes active. The new value stays pending and its flag stays set.
- R7: A capture strobe on a capture-mode channel (mode bit 1) stores the counter input into the buffer and sets the flag. On such a channel, software writes, update strobes and write-one-to-clear have no effect.
- R8: A read strobe on a capture channel with its flag set moves the buffer into the active register and clears the flag. A read with the flag clear changes nothing. If a capture and a read coincide, the old value goes active and the flag stays set, holding the new capture.
- R9: The period flag (status bit 7) and the pattern flag (status bit 5) set when their buffers are written. They clear on an update with lock low, which also copies the buffer to active, or on write-one-to-clear whatever the lock state.
- R10: Status bits 24 to 29 follow the compare-level inputs in the same cycle. Bits 0 to 4, 6, 8 to 15, 22, 23, 30 and 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_mode | input | 6 | Per-channel mode: 0 compare, 1 capture |
| lock_upd | input | 1 | Lock-update control; holds back buffer transfers |
| update | input | 1 | Update event strobe |
| buf_wr | input | 6 | Per-channel buffer write strobes |
| per_wr | input | 1 | Period buffer write strobe |
| pat_wr | input | 1 | Pattern buffer write strobe |
| wr_data | input | 16 | Shared write data for buffer writes |
| cap_evt | input | 6 | Per-channel capture strobes |
| count | input | 16 | Counter value sampled on capture |
| act_rd | input | 6 | Per-channel active-register read strobes |
| w1c | input | 1 | Write-one-to-clear strobe on the status word |
| w1c_mask | input | 32 | Bits to clear, same positions as status |
| cmp_lvl | input | 6 | Compare-output levels from waveform logic |
| status | output | 32 | Status word |
| act_val | output | 96 | Active values, channel i at bits 16i+15:16i |
| per_act | output | 16 | Active period value |
| pat_act | output | 16 | Active pattern value |

## Verification
The properties assume that every strobe lasts exactly one cycle and is sampled at a clock edge. They also assume that reset is held for at least one edge before any strobe, and that a channel's mode bit stays constant while its pending value matters. The stimulus sets the mode vector once, before reset is released, and never changes it. It applies each strobe as a single-cycle pulse aligned to the clock, so flag and transfer outcomes are never ambiguous. Coinciding events appear only in the deliberate collision cases of R6 and R8.

// File: rtl/ccbuf_pkg.sv
package ccbuf_pkg;
    localparam int NUM_CH  = 6;
    localparam int DATA_W  = 16;
    localparam int STAT_W  = 32;
    localparam int VLD_LSB = 16;
    localparam int CMP_LSB = 24;
    localparam int PER_BIT = 7;
    localparam int PAT_BIT = 5;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_CAP = 1'b1
    } ch_mode_e;

    function automatic logic xfer_now(input logic upd, input logic lock);
        return upd && !lock;
    endfunction
endpackage

// File: rtl/ccbuf_chan.sv
module ccbuf_chan
    import ccbuf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_mode_e      mode,
    input  logic          lock,
    input  logic          upd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          cap,
    input  logic [DW-1:0] cnt,
    input  logic          rd,
    input  logic          clr,
    output logic          vld,
    output logic [DW-1:0] act
);
    logic [DW-1:0] pend;
    logic          do_xfer;

    assign do_xfer = xfer_now(upd, lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
            vld  <= 1'b0;
        end else if (mode == MODE_CAP) begin
            if (rd && vld) act <= pend;
            if (cap) begin
                pend <= cnt;
                vld  <= 1'b1;
            end else if (rd) begin
                vld  <= 1'b0;
            end
        end else begin
            if (do_xfer && vld) act <= pend;
            if (wr) begin
                pend <= wdata;
                vld  <= 1'b1;
            end else if (do_xfer || (clr && lock)) begin
                vld  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccbuf_aux.sv
module ccbuf_aux
    import ccbuf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          upd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          clr,
    output logic          vld,
    output logic [DW-1:0] act
);
    logic [DW-1:0] pend;
    logic          do_xfer;

    assign do_xfer = xfer_now(upd, lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
            vld  <= 1'b0;
        end else begin
            if (do_xfer && vld) act <= pend;
            if (wr) begin
                pend <= wdata;
                vld  <= 1'b1;
            end else if (do_xfer || clr) begin
                vld  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccbuf_bank.sv
module ccbuf_bank
    import ccbuf_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_mode,
    input  logic              lock_upd,
    input  logic              update,
    input  logic [NCH-1:0]    buf_wr,
    input  logic              per_wr,
    input  logic              pat_wr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    cap_evt,
    input  logic [DW-1:0]     count,
    input  logic [NCH-1:0]    act_rd,
    input  logic              w1c,
    input  logic [STAT_W-1:0] w1c_mask,
    input  logic [NCH-1:0]    cmp_lvl,
    output logic [STAT_W-1:0] status,
    output logic [NCH*DW-1:0] act_val,
    output logic [DW-1:0]     per_act,
    output logic [DW-1:0]     pat_act
);
    logic [NCH-1:0] ch_vld;
    logic           per_vld;
    logic           pat_vld;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ccbuf_chan #(.DW(DW)) i_chan (
            .clk   (clk),
            .rst   (rst),
            .mode  (ch_mode_e'(ch_mode[i])),
            .lock  (lock_upd),
            .upd   (update),
            .wr    (buf_wr[i]),
            .wdata (wr_data),
            .cap   (cap_evt[i]),
            .cnt   (count),
            .rd    (act_rd[i]),
            .clr   (w1c && w1c_mask[VLD_LSB+i]),
            .vld   (ch_vld[i]),
            .act   (act_val[i*DW +: DW])
        );
    end

    ccbuf_aux #(.DW(DW)) i_per (
        .clk   (clk),
        .rst   (rst),
        .lock  (lock_upd),
        .upd   (update),
        .wr    (per_wr),
        .wdata (wr_data),
        .clr   (w1c && w1c_mask[PER_BIT]),
        .vld   (per_vld),
        .act   (per_act)
    );

    ccbuf_aux #(.DW(DW)) i_pat (
        .clk   (clk),
        .rst   (rst),
        .lock  (lock_upd),
        .upd   (update),
        .wr    (pat_wr),
        .wdata (wr_data),
        .clr   (w1c && w1c_mask[PAT_BIT]),
        .vld   (pat_vld),
        .act   (pat_act)
    );

    always_comb begin
        status          = '0;
        status[PER_BIT] = per_vld;
        status[PAT_BIT] = pat_vld;
        for (int i = 0; i < NCH; i++) begin
            status[VLD_LSB+i] = ch_vld[i];
            status[CMP_LSB+i] = cmp_lvl[i];
        end
    end
endmodule

// File: rtl/ccbuf_bank_chk.sv
module ccbuf_bank_chk
    import ccbuf_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    ch_mode,
    input logic              lock_upd,
    input logic              update,
    input logic [NCH-1:0]    buf_wr,
    input logic [NCH-1:0]    cap_evt,
    input logic [NCH-1:0]    act_rd,
    input logic              w1c,
    input logic [STAT_W-1:0] w1c_mask,
    input logic [STAT_W-1:0] status,
    input logic [NCH*DW-1:0] act_val
);
    function automatic logic [STAT_W-1:0] used_bits();
        logic [STAT_W-1:0] m;
        m = '0;
        m[PER_BIT] = 1'b1;
        m[PAT_BIT] = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            m[VLD_LSB+i] = 1'b1;
            m[CMP_LSB+i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [STAT_W-1:0] RSVD = ~used_bits();

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (status & RSVD) == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_p
        p_wr_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (!ch_mode[i] && buf_wr[i]) |=> status[VLD_LSB+i]);

        p_upd_clears_r3: assert property (@(posedge clk) disable iff (rst)
            (!ch_mode[i] && update && !lock_upd && !buf_wr[i]) |=> !status[VLD_LSB+i]);

        p_act_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!update && !act_rd[i]) |=> $stable(act_val[i*DW +: DW]));

        p_lock_keeps_r4: assert property (@(posedge clk) disable iff (rst)
            (!ch_mode[i] && update && lock_upd && status[VLD_LSB+i]
             && !(w1c && w1c_mask[VLD_LSB+i])) |=> status[VLD_LSB+i]);

        p_w1c_ignored_r5: assert property (@(posedge clk) disable iff (rst)
            (!ch_mode[i] && status[VLD_LSB+i] && w1c && w1c_mask[VLD_LSB+i]
             && !lock_upd && !update) |=> status[VLD_LSB+i]);

        p_cap_sets_r7: assert property (@(posedge clk) disable iff (rst)
            (ch_mode[i] && cap_evt[i]) |=> status[VLD_LSB+i]);

        p_rd_clears_r8: assert property (@(posedge clk) disable iff (rst)
            (ch_mode[i] && act_rd[i] && !cap_evt[i]) |=> !status[VLD_LSB+i]);
    end
endmodule

bind ccbuf_bank ccbuf_bank_chk #(.NCH(NCH), .DW(DW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_mode  (ch_mode),
    .lock_upd (lock_upd),
    .update   (update),
    .buf_wr   (buf_wr),
    .cap_evt  (cap_evt),
    .act_rd   (act_rd),
    .w1c      (w1c),
    .w1c_mask (w1c_mask),
    .status   (status),
    .act_val  (act_val)
);

// File: tb/test_ccbuf_bank.sv
module test_ccbuf_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int DW  = 16;

    typedef struct {
        string              tag;
        logic [31:0]        st;
        logic [NCH*DW-1:0]  act;
        logic [DW-1:0]      per;
        logic [DW-1:0]      pat;
    } exp_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rst, lock_upd, update, per_wr, pat_wr, w1c;
    logic [NCH-1:0]    ch_mode, buf_wr, cap_evt, act_rd, cmp_lvl;
    logic [DW-1:0]     wr_data, count;
    logic [31:0]       w1c_mask, status;
    logic [NCH*DW-1:0] act_val;
    logic [DW-1:0]     per_act, pat_act;

    ccbuf_bank i_ccbuf_bank (
        .clk(clk), .rst(rst), .ch_mode(ch_mode), .lock_upd(lock_upd),
        .update(update), .buf_wr(buf_wr), .per_wr(per_wr), .pat_wr(pat_wr),
        .wr_data(wr_data), .cap_evt(cap_evt), .count(count), .act_rd(act_rd),
        .w1c(w1c), .w1c_mask(w1c_mask), .cmp_lvl(cmp_lvl), .status(status),
        .act_val(act_val), .per_act(per_act), .pat_act(pat_act)
    );

    // next-cycle stimulus
    logic              n_rst = 1'b1, n_lock = 1'b0, n_upd = 1'b0;
    logic              n_perw = 1'b0, n_patw = 1'b0, n_w1c = 1'b0;
    logic [NCH-1:0]    n_mode = 6'b100000, n_wr = '0, n_cap = '0, n_rd = '0, n_cmp = '0;
    logic [DW-1:0]     n_data = '0, n_cnt = '0;
    logic [31:0]       n_mask = '0;
    string             n_tag = "R1";

    // requirement model
    logic          m_vld [NCH];
    logic [DW-1:0] m_buf [NCH];
    logic [DW-1:0] m_act [NCH];
    logic          mp_vld, mt_vld;
    logic [DW-1:0] mp_buf, mp_act, mt_buf, mt_act;

    exp_t q[$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    initial begin
        rst = 1'b1; ch_mode = n_mode; lock_upd = 0; update = 0; buf_wr = 0;
        per_wr = 0; pat_wr = 0; wr_data = 0; cap_evt = 0; count = 0;
        act_rd = 0; w1c = 0; w1c_mask = 0; cmp_lvl = 0;
    end

    task automatic model_clock();
        bit xf;
        xf = n_upd && !n_lock;
        if (n_rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_vld[i] = 0; m_buf[i] = 0; m_act[i] = 0;
            end
            mp_vld = 0; mp_buf = 0; mp_act = 0;
            mt_vld = 0; mt_buf = 0; mt_act = 0;
            return;
        end
        for (int i = 0; i < NCH; i++) begin
            if (n_mode[i]) begin
                if (n_rd[i] && m_vld[i]) m_act[i] = m_buf[i];
                if (n_cap[i]) begin m_buf[i] = n_cnt; m_vld[i] = 1; end
                else if (n_rd[i]) m_vld[i] = 0;
            end else begin
                if (xf && m_vld[i]) m_act[i] = m_buf[i];
                if (n_wr[i]) begin m_buf[i] = n_data; m_vld[i] = 1; end
                else if (xf || (n_w1c && n_mask[16+i] && n_lock)) m_vld[i] = 0;
            end
        end
        if (xf && mp_vld) mp_act = mp_buf;
        if (n_perw) begin mp_buf = n_data; mp_vld = 1; end
        else if (xf || (n_w1c && n_mask[7])) mp_vld = 0;
        if (xf && mt_vld) mt_act = mt_buf;
        if (n_patw) begin mt_buf = n_data; mt_vld = 1; end
        else if (xf || (n_w1c && n_mask[5])) mt_vld = 0;
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk); #1;
        rst = n_rst; ch_mode = n_mode; lock_upd = n_lock; update = n_upd;
        buf_wr = n_wr; per_wr = n_perw; pat_wr = n_patw; wr_data = n_data;
        cap_evt = n_cap; count = n_cnt; act_rd = n_rd; w1c = n_w1c;
        w1c_mask = n_mask; cmp_lvl = n_cmp;
        @(posedge clk);
        model_clock();
        e.tag = n_tag;
        e.st = '0;
        e.st[7] = mp_vld;
        e.st[5] = mt_vld;
        for (int i = 0; i < NCH; i++) begin
            e.st[16+i] = m_vld[i];
            e.st[24+i] = n_cmp[i];
            e.act[i*DW +: DW] = m_act[i];
        end
        e.per = mp_act;
        e.pat = mt_act;
        q.push_back(e);
        // strobes last one cycle
        n_upd = 0; n_wr = '0; n_perw = 0; n_patw = 0; n_cap = '0;
        n_rd = '0; n_w1c = 0; n_mask = '0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (status !== e.st || act_val !== e.act || per_act !== e.per || pat_act !== e.pat) begin
                miscompares++;
                $display("FAIL %s: status=%h act=%h per=%h pat=%h expected status=%h act=%h per=%h pat=%h",
                         e.tag, status, act_val, per_act, pat_act, e.st, e.act, e.per, e.pat);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        n_tag = "R1"; n_rst = 1; step(); step();
        n_rst = 0; step();
        // R2 compare writes set flags
        n_tag = "R2"; n_wr = 6'b000001; n_data = 16'h1111; step();
        n_tag = "R2"; n_wr = 6'b001000; n_data = 16'h3333; step();
        // R4 locked update holds
        n_tag = "R4"; n_lock = 1; n_upd = 1; step();
        // R5 w1c ignored while unlocked
        n_tag = "R5"; n_lock = 0; n_w1c = 1; n_mask = 32'h0008_0000; step();
        // R3 update transfers and clears
        n_tag = "R3"; n_upd = 1; step();
        n_tag = "R3"; step();
        // R5 w1c with lock clears pending value
        n_tag = "R5"; n_wr = 6'b000010; n_data = 16'hAAAA; step();
        n_tag = "R5"; n_lock = 1; n_w1c = 1; n_mask = 32'h0002_0000; step();
        n_tag = "R5"; n_lock = 0; n_upd = 1; step();
        // R6 write colliding with update
        n_tag = "R6"; n_wr = 6'b000100; n_data = 16'h2222; step();
        n_tag = "R6"; n_wr = 6'b000100; n_data = 16'h2BBB; n_upd = 1; step();
        n_tag = "R6"; n_upd = 1; step();
        // R7 capture channel 5
        n_tag = "R7"; n_cap = 6'b100000; n_cnt = 16'h5A5A; step();
        n_tag = "R7"; n_wr = 6'b100000; n_data = 16'hFFFF; n_upd = 1; step();
        n_tag = "R7"; n_lock = 1; n_w1c = 1; n_mask = 32'h0020_0000; step();
        n_tag = "R7"; n_lock = 0; n_upd = 1; step();
        // R8 read consumes
        n_tag = "R8"; n_rd = 6'b100000; step();
        n_tag = "R8"; n_rd = 6'b100000; step();
        n_tag = "R8"; n_cap = 6'b100000; n_cnt = 16'h0777; step();
        n_tag = "R8"; n_cap = 6'b100000; n_cnt = 16'h0888; n_rd = 6'b100000; step();
        n_tag = "R8"; n_rd = 6'b100000; step();
        // R9 period and pattern
        n_tag = "R9"; n_perw = 1; n_data = 16'h1234; step();
        n_tag = "R9"; n_patw = 1; n_data = 16'h00C3; step();
        n_tag = "R9"; n_lock = 1; n_upd = 1; step();
        n_tag = "R9"; n_lock = 0; n_w1c = 1; n_mask = 32'h0000_0080; step();
        n_tag = "R9"; n_upd = 1; step();
        n_tag = "R9"; n_patw = 1; n_data = 16'h0055; step();
        n_tag = "R9"; n_lock = 1; n_w1c = 1; n_mask = 32'h0000_0020; step();
        n_lock = 0;
        // R10 compare levels and reserved bits
        n_tag = "R10"; n_cmp = 6'b101010; step();
        n_tag = "R10"; n_cmp = 6'b010101; n_w1c = 1; n_mask = 32'hFFFF_FFFF; step();
        n_tag = "R10"; step();
        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule